// File: doc/BRIEF.md
# Calibration Pulse-to-Trigger Delay Generator

This block drives one calibration test pulse and, a programmable time later, one trigger pulse. It is used in charge-injection calibration scans. Stepping the requested delay across its range samples the shaped analogue response at many points, so the pulse can be rebuilt and its peak found. Software writes the delay as a whole number of nanoseconds, from 0 to 255. The block splits that number into two parts. The coarse part counts whole periods of the fast clock (5 ns at the nominal 200 MHz). The fine part is a tap code from 0 to 4 that goes to an external sub-period delay element on the trigger path.

A fixed intrinsic latency is always added to the coarse count. With a requested delay of zero, the trigger still lands where the front-end pipeline expects it. The block also selects the sign of each injected charge. The sign flips on every accepted injection, and it also depends on the parity of the channel number.

Top module: `cal_pulse_delay`

## Requirements
- R1: While reset is high and in the first cycle after it, `tp_out`, `trig_out`, `busy` and `pulse_neg` are 0 and `fine_tap` is 0.
- R2: A write with `cfg_we` high stores `cfg_delay_ns`. The next accepted request drives `fine_tap` with `cfg_delay_ns % 5` and uses `cfg_delay_ns / 5` as the coarse period count.
- R3: If a request (`cal_req` high while enabled and not busy) is sampled at a clock edge, `tp_out` is high for exactly one cycle right after that edge. Each accepted request produces exactly one test pulse.
- R4: `trig_out` rises exactly 133 + coarse clock cycles after `tp_out` rises (pipeline latency 128 plus pad 5) and stays high for one cycle.
- R5: When the external element adds `fine_tap` ns to the trigger, the trigger arrives 5 × (cycles − 133) + `fine_tap` ns after the pulse, and this equals the requested delay for every value from 0 to 255.
- R6: `busy` is high from the `tp_out` cycle through the `trig_out` cycle. Requests sampled while `busy` is high produce no test pulse.
- R7: With the calibration enable bit stored as 0, requests produce no test pulse and `busy` stays low.
- R8: A configuration write made while `busy` is high changes neither the running trigger time nor `fine_tap`. `fine_tap` and `pulse_neg` stay stable until `busy` falls.
- R9: `pulse_neg` (0 = positive charge, 1 = negative) is loaded with the same edge as `tp_out`, as an injection toggle XOR `cal_chan[0]`. The toggle is 0 after reset and inverts on every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (coarse delay unit) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cal_en | input | 1 | Calibration enable value to store |
| cfg_delay_ns | input | 8 | Requested delay in ns to store |
| cal_req | input | 1 | Calibration request |
| cal_chan | input | 7 | Channel number of the injection |
| tp_out | output | 1 | Test pulse, one cycle |
| trig_out | output | 1 | Trigger before fine delay, one cycle |
| fine_tap | output | 3 | Fine tap code for the external delay element |
| pulse_neg | output | 1 | Injected charge sign, 1 = negative |
| busy | output | 1 | Sequence in progress |

## Verification
The bench uses the default parameters: a 128-cycle pipeline latency, a 5-cycle pad, a 5 ns clock unit and a 6-bit coarse field. Every delay therefore falls between 133 and 184 cycles, so the whole 0 to 255 ns range can be tested directly, including the ends and both fine-code wrap points (4 and 5 ns). A bench model of the fine element turns the measured cycle count and tap code back into nanoseconds, so a wrong split between coarse and fine shows up as a wrong total.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
    localparam int NS_W       = 8;
    localparam int COARSE_W   = 6;
    localparam int FINE_W     = 3;
    localparam int NS_PER_CLK = 5;

    typedef struct packed {
        logic                en;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } cal_cfg_t;

    function automatic cal_cfg_t split_delay(input logic en, input logic [NS_W-1:0] ns);
        cal_cfg_t c;
        c.en     = en;
        c.coarse = COARSE_W'(ns / NS_W'(NS_PER_CLK));
        c.fine   = FINE_W'(ns % NS_W'(NS_PER_CLK));
        return c;
    endfunction
endpackage

// File: rtl/cpd_cfg_regs.sv
module cpd_cfg_regs
    import cpd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            en_in,
    input  logic [NS_W-1:0] ns_in,
    output cal_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else if (we) cfg <= split_delay(en_in, ns_in);
    end
endmodule

// File: rtl/cpd_seq.sv
module cpd_seq
    import cpd_pkg::*;
#(
    parameter int BASE_CYC = 133
) (
    input  logic              clk,
    input  logic              rst,
    input  cal_cfg_t          cfg,
    input  logic              req,
    output logic              accept,
    output logic              tp,
    output logic              trig,
    output logic              busy,
    output logic [FINE_W-1:0] fine_tap
);
    localparam int MAX_CYC = BASE_CYC + (1 << COARSE_W);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    assign accept = !busy && cfg.en && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            tp <= 1'b0; trig <= 1'b0; busy <= 1'b0;
            cnt <= '0; fine_tap <= '0;
        end else begin
            tp   <= 1'b0;
            trig <= 1'b0;
            if (!busy) begin
                if (accept) begin
                    tp       <= 1'b1;
                    busy     <= 1'b1;
                    cnt      <= CNT_W'(BASE_CYC) + CNT_W'(cfg.coarse) - CNT_W'(1);
                    fine_tap <= cfg.fine;
                end
            end else if (trig) begin
                busy <= 1'b0;
            end else if (cnt == '0) begin
                trig <= 1'b1;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    a_r3_tp_one_wide: assert property (@(posedge clk) disable iff (rst) tp |=> !tp);
    a_r4_trig_one_wide: assert property (@(posedge clk) disable iff (rst) trig |=> !trig);
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst) (busy && req) |=> !tp);
    a_r6_trig_in_busy: assert property (@(posedge clk) disable iff (rst) trig |-> busy);
    a_r7_disabled_idle: assert property (@(posedge clk) disable iff (rst) (!cfg.en && !busy) |=> !tp);
    a_r8_fine_hold: assert property (@(posedge clk) disable iff (rst) (busy && !tp) |-> $stable(fine_tap));
endmodule

// File: rtl/cpd_polarity.sv
module cpd_polarity #(
    parameter int CHAN_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [CHAN_W-1:0] chan,
    output logic              pol_neg
);
    logic flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            flip <= 1'b0; pol_neg <= 1'b0;
        end else if (accept) begin
            pol_neg <= flip ^ chan[0];
            flip    <= ~flip;
        end
    end

    a_r9_flip_toggles: assert property (@(posedge clk) disable iff (rst) accept |=> (flip != $past(flip)));
    a_r8_pol_hold: assert property (@(posedge clk) disable iff (rst) !accept |=> $stable(pol_neg));
endmodule

// File: rtl/cal_pulse_delay.sv
module cal_pulse_delay
    import cpd_pkg::*;
#(
    parameter int PIPE_LAT = 128,
    parameter int PAD_LAT  = 5,
    parameter int CHAN_W   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_cal_en,
    input  logic [NS_W-1:0]   cfg_delay_ns,
    input  logic              cal_req,
    input  logic [CHAN_W-1:0] cal_chan,
    output logic              tp_out,
    output logic              trig_out,
    output logic [FINE_W-1:0] fine_tap,
    output logic              pulse_neg,
    output logic              busy
);
    localparam int BASE_CYC = PIPE_LAT + PAD_LAT;

    cal_cfg_t cfg;
    logic     accept;

    cpd_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .en_in(cfg_cal_en),
        .ns_in(cfg_delay_ns), .cfg(cfg)
    );

    cpd_seq #(.BASE_CYC(BASE_CYC)) u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .req(cal_req), .accept(accept),
        .tp(tp_out), .trig(trig_out), .busy(busy), .fine_tap(fine_tap)
    );

    cpd_polarity #(.CHAN_W(CHAN_W)) u_pol (
        .clk(clk), .rst(rst), .accept(accept), .chan(cal_chan), .pol_neg(pulse_neg)
    );
endmodule

// File: tb/tb_cal_pulse_delay.sv
module tb_cal_pulse_delay;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_cal_en = 1'b0, cal_req = 1'b0;
    logic [7:0] cfg_delay_ns = '0;
    logic [6:0] cal_chan = '0;
    logic       tp_out, trig_out, pulse_neg, busy;
    logic [2:0] fine_tap;

    int checks = 0, errors = 0;
    bit toggle = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cal_pulse_delay dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cal_en(cfg_cal_en),
        .cfg_delay_ns(cfg_delay_ns), .cal_req(cal_req), .cal_chan(cal_chan),
        .tp_out(tp_out), .trig_out(trig_out), .fine_tap(fine_tap),
        .pulse_neg(pulse_neg), .busy(busy)
    );

    function automatic int exp_cycles(input int ns);
        return 133 + ns / 5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit en, input int ns);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cal_en = en; cfg_delay_ns = 8'(ns);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Full sequence; optional mid-run write and blocked request.
    task automatic run_cal(input int ns, input int chan, input bit disturb);
        int k;
        bit exp_pol;
        bit tp_extra;
        logic [2:0] f0;
        write_cfg(1'b1, ns);
        cal_chan = 7'(chan);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        check(tp_out === 1'b1 && busy === 1'b1, "R3", int'(tp_out), 1);
        exp_pol = toggle ^ chan[0];
        toggle = ~toggle;
        check(pulse_neg === exp_pol, "R9", int'(pulse_neg), int'(exp_pol));
        check(fine_tap === 3'(ns % 5), "R2", int'(fine_tap), ns % 5);
        f0 = fine_tap;
        k = 0;
        tp_extra = 1'b0;
        while (trig_out !== 1'b1 && k < 400) begin
            if (disturb && k == 10) begin
                cfg_we = 1'b1; cfg_delay_ns = 8'((ns + 7) % 256);
                cal_req = 1'b1;
            end else begin
                cfg_we = 1'b0; cal_req = 1'b0;
            end
            @(negedge clk);
            k++;
            if (tp_out === 1'b1) tp_extra = 1'b1;
            if (busy !== 1'b1 || fine_tap !== f0) tp_extra = 1'b1;
        end
        cfg_we = 1'b0; cal_req = 1'b0;
        check(!tp_extra, disturb ? "R8" : "R6", int'(tp_extra), 0);
        check(k == exp_cycles(ns), "R4", k, exp_cycles(ns));
        check((k - 133) * 5 + int'(fine_tap) == ns, "R5", (k - 133) * 5 + int'(fine_tap), ns);
        check(busy === 1'b1, "R6", int'(busy), 1);
        @(negedge clk);
        check(trig_out === 1'b0 && busy === 1'b0, "R4", int'(trig_out), 0);
        if (disturb) write_cfg(1'b1, ns);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        int v;
        seed = 1234;
        v = $urandom(seed);
        repeat (3) @(negedge clk);
        check(tp_out === 0 && trig_out === 0 && busy === 0 && pulse_neg === 0 && fine_tap === 0,
              "R1", int'(tp_out | trig_out | busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 0 && tp_out === 0, "R1", int'(busy), 0);

        // R7: disabled requests ignored
        write_cfg(1'b0, 40);
        cal_req = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(tp_out === 0 && busy === 0, "R7", int'(tp_out | busy), 0);
        end
        cal_req = 1'b0;

        // directed corners
        run_cal(0, 0, 1'b0);
        run_cal(4, 1, 1'b0);
        run_cal(5, 2, 1'b0);
        run_cal(254, 3, 1'b0);
        run_cal(255, 5, 1'b0);
        // R8: write and request during busy
        run_cal(99, 6, 1'b1);
        run_cal(12, 9, 1'b0);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_cal(int'($urandom % 256), int'($urandom % 128), 1'b0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule